// File: doc/BRIEF.md
# Two-Plane Cached Page Program Sequencer

This block sits on the host side of a NAND-style flash channel and turns one page-pair request into the complete bus transaction of a two-plane cached program. A request carries two five-byte page addresses (one for each plane), a byte count for each page and a flag that marks the final pair. The sequencer checks the two addresses against the plane-pairing rules. It then drives command-latch, address-latch and data cycles with a write strobe on an 8-bit bus, pulls page bytes from an indexed data source, and waits on the device ready/busy line after every confirm command.

A stream of pages is programmed by issuing one request after another. Every pair except the last is closed with the cache confirm, so the device can program the previous pair while the host loads the next one. The last pair is closed with the plain program confirm. A request that breaks a plane rule is refused at once with an error pulse, and the bus stays quiet.

States: `S_IDLE` (accept request) → `S_REJ` (rule broken, back to idle) or `S_C80` → `S_A0` (five address cycles) → `S_D0` (page-0 bytes, skipped if count is zero) → `S_C11` → `S_W11` (strobe engine drains) → `S_B11` (wait ready) → `S_C81` → `S_A1` → `S_D1` (skipped if count is zero) → `S_CFIN` (15h or 10h) → `S_WFIN` → `S_BFIN` → `S_DONE` → `S_IDLE`.

Top module: `mpcp_pair_seq`

## Requirements
- R1: A request is taken only in the idle state while ready/busy is high; `req_ready` is high exactly in the idle state and low while a pair or a refusal is being handled.
- R2: An accepted pair produces, in order: command 80h, five address cycles of the first address, the first page bytes, command 11h, a wait for ready, command 81h, five address cycles of the second address, the second page bytes, then the closing command.
- R3: The closing command is 15h when `req_last` is 0 and 10h when `req_last` is 1.
- R4: Address cycles send the 40-bit address least significant byte first. The row address is bits 39:16. The plane-select bit is row bit PAGE_BITS (address bit 22 by default), and the block bits are the address bits above it.
- R5: A request whose first address has plane bit 1, or whose second address has plane bit 0, is refused.
- R6: A request whose two addresses differ in any address bit above the plane bit is refused.
- R7: A refusal gives a one-cycle `seq_err` pulse and no write strobe at all.
- R8: Every bus cycle holds `nand_we_n` low for `strobe_clks` clocks (0 counts as 1), then high for at least one clock, with the latched value held. `nand_cle` is high only for commands and `nand_ale` only for addresses, and they are never high together.
- R9: After each confirm command (11h, 15h, 10h), no write strobe starts until the strobe has finished and ready/busy reads high.
- R10: Exactly the given number of bytes is sent for each page, and a count of zero sends none. Byte k of plane p is taken from `dat_in` while `dat_plane`=p and `dat_idx`=k.
- R11: `seq_done` pulses for one cycle once ready/busy is high after the closing command.
- R12: After reset the block is idle: `req_ready`=1, `nand_we_n`=1, `nand_cle`=`nand_ale`=0, and no done or error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr0 | input | 40 | Page address for plane 0 |
| req_addr1 | input | 40 | Page address for plane 1 |
| req_len0 | input | LEN_W | Byte count for the plane-0 page |
| req_len1 | input | LEN_W | Byte count for the plane-1 page |
| req_last | input | 1 | Pair is the final one of the stream |
| strobe_clks | input | CNT_W | Write strobe low time in clocks |
| dat_in | input | 8 | Page byte selected by dat_plane and dat_idx |
| dat_plane | output | 1 | Plane whose byte is requested |
| dat_idx | output | LEN_W | Index of the requested byte |
| dat_take | output | 1 | The byte on dat_in is consumed this cycle |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | 8 | Bus byte |
| nand_rb_n | input | 1 | Device ready (1) or busy (0) |
| seq_done | output | 1 | Pair complete pulse |
| seq_err | output | 1 | Request refused pulse |

## Verification
Two events can land in the same cycle. The device can raise ready/busy in the cycle the sequencer makes its first ready check after a confirm. The strobe engine can also finish one bus cycle's high phase in the cycle the sequencer issues the next cycle, for example the last page byte followed at once by a command. Busy times of zero and one clock with a one-clock strobe, and pages of zero or one byte, bring these coincidences about. The bench model then judges each latched bus cycle against the expected queue and checks that no strobe overlapped a busy period and that every low phase kept its width.

// File: rtl/mpcp_pkg.sv
package mpcp_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_REJ,
        S_C80, S_A0, S_D0, S_C11, S_W11, S_B11,
        S_C81, S_A1, S_D1, S_CFIN, S_WFIN, S_BFIN,
        S_DONE
    } seq_st_t;

    typedef enum logic [1:0] {K_CMD, K_ADR, K_DAT} cyc_kind_t;

    typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} eng_st_t;

    localparam logic [7:0] CMD_LOAD0 = 8'h80;
    localparam logic [7:0] CMD_DUMMY = 8'h11;
    localparam logic [7:0] CMD_LOAD1 = 8'h81;
    localparam logic [7:0] CMD_CACHE = 8'h15;
    localparam logic [7:0] CMD_FINAL = 8'h10;

endpackage

// File: rtl/mpcp_addr_chk.sv
module mpcp_addr_chk #(
    parameter int BLK_W = 18
) (
    input  logic [BLK_W-1:0] blk0,
    input  logic [BLK_W-1:0] blk1,
    output logic             plane_ok,
    output logic             block_ok
);
    // bit 0 of each slice is the plane select; the rest must match
    assign plane_ok = !blk0[0] && blk1[0];
    assign block_ok = (blk0[BLK_W-1:1] == blk1[BLK_W-1:1]);
endmodule

// File: rtl/mpcp_bus_cycle.sv
module mpcp_bus_cycle
    import mpcp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  cyc_kind_t        kind,
    input  logic [7:0]       byte_in,
    input  logic [CNT_W-1:0] low_clks,
    output logic             rdy,
    output logic             idle,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic [7:0]       io
);
    eng_st_t          st;
    logic [CNT_W-1:0] cnt;
    cyc_kind_t        kind_q;
    logic [7:0]       io_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= E_IDLE;
            cnt    <= '0;
            kind_q <= K_CMD;
            io_q   <= '0;
        end else begin
            unique case (st)
                E_IDLE, E_HIGH: begin
                    if (go) begin
                        st     <= E_LOW;
                        cnt    <= (low_clks == '0) ? '0 : low_clks - 1'b1;
                        kind_q <= kind;
                        io_q   <= byte_in;
                    end else begin
                        st <= E_IDLE;
                    end
                end
                E_LOW: begin
                    if (cnt == '0) st <= E_HIGH;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        rdy  = (st != E_LOW);
        idle = (st == E_IDLE);
        we_n = (st != E_LOW);
        cle  = (st != E_IDLE) && (kind_q == K_CMD);
        ale  = (st != E_IDLE) && (kind_q == K_ADR);
        io   = (st != E_IDLE) ? io_q : 8'h00;
    end

    // R8
    io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(io));
endmodule

// File: rtl/mpcp_pair_seq.sv
module mpcp_pair_seq
    import mpcp_pkg::*;
#(
    parameter int LEN_W     = 12,
    parameter int CNT_W     = 4,
    parameter int PAGE_BITS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [39:0]      req_addr0,
    input  logic [39:0]      req_addr1,
    input  logic [LEN_W-1:0] req_len0,
    input  logic [LEN_W-1:0] req_len1,
    input  logic             req_last,
    input  logic [CNT_W-1:0] strobe_clks,
    input  logic [7:0]       dat_in,
    output logic             dat_plane,
    output logic [LEN_W-1:0] dat_idx,
    output logic             dat_take,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic [7:0]       nand_io,
    input  logic             nand_rb_n,
    output logic             seq_done,
    output logic             seq_err
);
    localparam int ADDR_W    = 40;
    localparam int ADDR_CYC  = ADDR_W / 8;
    localparam int PLANE_POS = 16 + PAGE_BITS;
    localparam int BLK_W     = ADDR_W - PLANE_POS;
    localparam logic [2:0] ACNT_LAST = 3'(ADDR_CYC - 1);

    seq_st_t          st, st_d;
    logic [ADDR_W-1:0] a0_q, a1_q;
    logic [LEN_W-1:0] len0_q, len1_q;
    logic             last_q;
    logic [2:0]       acnt;
    logic [LEN_W-1:0] dcnt;

    logic             plane_ok, block_ok;
    logic             eng_go, eng_rdy, eng_idle;
    cyc_kind_t        eng_kind;
    logic [7:0]       eng_byte;
    logic             dat_last;

    mpcp_addr_chk #(.BLK_W(BLK_W)) u_chk (
        .blk0     (req_addr0[ADDR_W-1:PLANE_POS]),
        .blk1     (req_addr1[ADDR_W-1:PLANE_POS]),
        .plane_ok (plane_ok),
        .block_ok (block_ok)
    );

    mpcp_bus_cycle #(.CNT_W(CNT_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (eng_go),
        .kind     (eng_kind),
        .byte_in  (eng_byte),
        .low_clks (strobe_clks),
        .rdy      (eng_rdy),
        .idle     (eng_idle),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .we_n     (nand_we_n),
        .io       (nand_io)
    );

    function automatic logic [7:0] addr_byte(input logic [ADDR_W-1:0] a, input logic [2:0] i);
        logic [ADDR_W-1:0] s;
        s = a >> (i * 8);
        return s[7:0];
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_d;
    end

    // request capture and cycle counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a0_q <= '0; a1_q <= '0; len0_q <= '0; len1_q <= '0;
            last_q <= 1'b0; acnt <= '0; dcnt <= '0;
        end else begin
            if (st == S_IDLE && req_valid) begin
                a0_q   <= req_addr0;
                a1_q   <= req_addr1;
                len0_q <= req_len0;
                len1_q <= req_len1;
                last_q <= req_last;
            end
            if (eng_go && eng_kind == K_ADR)
                acnt <= (acnt == ACNT_LAST) ? '0 : acnt + 1'b1;
            if (eng_go && eng_kind == K_DAT)
                dcnt <= dat_last ? '0 : dcnt + 1'b1;
        end
    end

    assign dat_last = (st == S_D0) ? (dcnt == len0_q - 1'b1) : (dcnt == len1_q - 1'b1);

    // next state and issue
    always_comb begin
        st_d     = st;
        eng_go   = 1'b0;
        eng_kind = K_CMD;
        eng_byte = 8'h00;
        unique case (st)
            S_IDLE: if (req_valid && nand_rb_n) st_d = (plane_ok && block_ok) ? S_C80 : S_REJ;
            S_REJ:  st_d = S_IDLE;
            S_C80: if (eng_rdy) begin
                eng_go = 1'b1; eng_byte = CMD_LOAD0; st_d = S_A0;
            end
            S_A0: if (eng_rdy) begin
                eng_go = 1'b1; eng_kind = K_ADR; eng_byte = addr_byte(a0_q, acnt);
                if (acnt == ACNT_LAST) st_d = (len0_q == '0) ? S_C11 : S_D0;
            end
            S_D0: if (eng_rdy) begin
                eng_go = 1'b1; eng_kind = K_DAT; eng_byte = dat_in;
                if (dat_last) st_d = S_C11;
            end
            S_C11: if (eng_rdy) begin
                eng_go = 1'b1; eng_byte = CMD_DUMMY; st_d = S_W11;
            end
            S_W11: if (eng_idle) st_d = S_B11;
            S_B11: if (nand_rb_n) st_d = S_C81;
            S_C81: if (eng_rdy) begin
                eng_go = 1'b1; eng_byte = CMD_LOAD1; st_d = S_A1;
            end
            S_A1: if (eng_rdy) begin
                eng_go = 1'b1; eng_kind = K_ADR; eng_byte = addr_byte(a1_q, acnt);
                if (acnt == ACNT_LAST) st_d = (len1_q == '0) ? S_CFIN : S_D1;
            end
            S_D1: if (eng_rdy) begin
                eng_go = 1'b1; eng_kind = K_DAT; eng_byte = dat_in;
                if (dat_last) st_d = S_CFIN;
            end
            S_CFIN: if (eng_rdy) begin
                eng_go = 1'b1; eng_byte = last_q ? CMD_FINAL : CMD_CACHE; st_d = S_WFIN;
            end
            S_WFIN: if (eng_idle) st_d = S_BFIN;
            S_BFIN: if (nand_rb_n) st_d = S_DONE;
            S_DONE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (st == S_IDLE);
        seq_done  = (st == S_DONE);
        seq_err   = (st == S_REJ);
        dat_plane = (st == S_D1);
        dat_idx   = dcnt;
        dat_take  = eng_go && (eng_kind == K_DAT);
    end

    // R9
    rb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_rb_n |-> !eng_go);

    // R7
    rej_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (nand_we_n && !nand_cle && !nand_ale));

    // R11
    done_after_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> $past(nand_rb_n));

    // R2
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_D0 || st == S_D1 || st == S_C11 || st == S_CFIN) |-> (acnt == 3'd0));
endmodule

// File: tb/tb_mpcp_pair_seq.sv
module tb_mpcp_pair_seq;
    localparam int LEN_W = 12;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic             req_ready;
    logic [39:0]      req_addr0, req_addr1;
    logic [LEN_W-1:0] req_len0, req_len1;
    logic             req_last;
    logic [CNT_W-1:0] strobe_clks;
    logic [7:0]       dat_in;
    logic             dat_plane;
    logic [LEN_W-1:0] dat_idx;
    logic             dat_take;
    logic             nand_cle, nand_ale, nand_we_n;
    logic [7:0]       nand_io;
    logic             nand_rb_n;
    logic             seq_done, seq_err;

    logic dev_rb;
    logic hold_busy;
    int   cur_tag;
    int   busy_clks;
    int   total = 0;
    int   bad   = 0;
    int   ev_cnt = 0;
    int   done_cyc = 0;
    int   err_cyc = 0;

    int    q_kind[$];
    int    q_byte[$];
    string q_req[$];

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input int tag, input int plane, input int idx);
        return 8'((tag * 29 + plane * 83 + idx * 5 + 1) & 255);
    endfunction

    assign dat_in    = pat(cur_tag, int'(dat_plane), int'(dat_idx));
    assign nand_rb_n = dev_rb & ~hold_busy;

    mpcp_pair_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .PAGE_BITS(6)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr0(req_addr0), .req_addr1(req_addr1), .req_len0(req_len0),
        .req_len1(req_len1), .req_last(req_last), .strobe_clks(strobe_clks),
        .dat_in(dat_in), .dat_plane(dat_plane), .dat_idx(dat_idx), .dat_take(dat_take),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_io(nand_io), .nand_rb_n(nand_rb_n), .seq_done(seq_done), .seq_err(seq_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [39:0] mkaddr(input int blk, input int plane, input int page, input int col);
        logic [39:0] a;
        a = '0;
        a[15:0]  = col[15:0];
        a[21:16] = page[5:0];
        a[22]    = plane[0];
        a[39:23] = blk[16:0];
        return a;
    endfunction

    task automatic push(input int k, input int b, input string r);
        q_kind.push_back(k);
        q_byte.push_back(b);
        q_req.push_back(r);
    endtask

    // device model and per-clock comparison against the expected bus queue
    initial begin
        int  low_run;
        bit  busy_seen;
        bit  prev_we;
        int  busy_left;
        int  k, ek, eb, exp_low;
        string er;
        low_run = 0; busy_seen = 0; prev_we = 1; busy_left = 0; dev_rb = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                exp_low = (strobe_clks == '0) ? 1 : int'(strobe_clks);
                if (!nand_we_n) begin
                    low_run++;
                    if (!nand_rb_n) busy_seen = 1;
                end else if (!prev_we) begin
                    ev_cnt++;
                    check(low_run == exp_low, "R8 strobe width", low_run, exp_low);
                    check(!(nand_cle && nand_ale), "R8 latch exclusive", int'(nand_cle) + int'(nand_ale), 1);
                    check(!busy_seen, "R9 strobe during busy", int'(busy_seen), 0);
                    k = nand_cle ? 0 : (nand_ale ? 1 : 2);
                    if (q_kind.size() == 0) begin
                        check(0, "R2 unexpected bus cycle", k * 256 + int'(nand_io), -1);
                    end else begin
                        ek = q_kind.pop_front();
                        eb = q_byte.pop_front();
                        er = q_req.pop_front();
                        check(k == ek && int'(nand_io) == eb, er, k * 256 + int'(nand_io), ek * 256 + eb);
                    end
                    if (k == 0 && (nand_io == 8'h11 || nand_io == 8'h15 || nand_io == 8'h10))
                        busy_left = busy_clks;
                    low_run = 0;
                    busy_seen = 0;
                end
                prev_we = nand_we_n;
                if (busy_left > 0) begin
                    dev_rb = 1'b0;
                    busy_left--;
                end else begin
                    dev_rb = 1'b1;
                end
                if (seq_done) done_cyc++;
                if (seq_err)  err_cyc++;
            end
        end
    end

    task automatic run_pair(input logic [39:0] a0, input logic [39:0] a1, input int l0, input int l1,
                            input bit last, input int tag, input int strb, input int bsy,
                            input int hold, input bit ok, input string rej_req);
        int d0, e0, v0, n;
        if (ok) begin
            push(0, 8'h80, "R2 load-0 command");
            for (int i = 0; i < 5; i++) push(1, int'(a0[8*i +: 8]), "R4 address-0 byte");
            for (int i = 0; i < l0; i++) push(2, int'(pat(tag, 0, i)), "R10 plane-0 byte");
            push(0, 8'h11, "R2 dummy confirm");
            push(0, 8'h81, "R2 load-1 command");
            for (int i = 0; i < 5; i++) push(1, int'(a1[8*i +: 8]), "R4 address-1 byte");
            for (int i = 0; i < l1; i++) push(2, int'(pat(tag, 1, i)), "R10 plane-1 byte");
            push(0, last ? 8'h10 : 8'h15, "R3 closing command");
        end
        d0 = done_cyc; e0 = err_cyc; v0 = ev_cnt;
        @(negedge clk);
        cur_tag     = tag;
        busy_clks   = bsy;
        strobe_clks = CNT_W'(strb);
        req_addr0   = a0;
        req_addr1   = a1;
        req_len0    = LEN_W'(l0);
        req_len1    = LEN_W'(l1);
        req_last    = last;
        req_valid   = 1'b1;
        if (hold > 0) begin
            hold_busy = 1'b1;
            repeat (hold) @(negedge clk);
            check(ev_cnt == v0 && req_ready, "R1 held off while busy", ev_cnt - v0, 0);
            hold_busy = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R1 ready drops once taken", int'(req_ready), 0);
        n = 0;
        while (done_cyc == d0 && err_cyc == e0 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(n < 4000, "R11 pair completes", n, 4000);
        @(negedge clk);
        if (ok) begin
            check(done_cyc == d0 + 1, "R11 single done pulse", done_cyc - d0, 1);
            check(err_cyc == e0, "R11 no error on valid pair", err_cyc - e0, 0);
            check(q_kind.size() == 0, "R10 all expected cycles seen", q_kind.size(), 0);
        end else begin
            check(err_cyc == e0 + 1, rej_req, err_cyc - e0, 1);
            check(done_cyc == d0, "R7 no done on refusal", done_cyc - d0, 0);
            check(ev_cnt == v0, "R7 no strobes on refusal", ev_cnt - v0, 0);
        end
        check(req_ready, "R1 idle after pair", int'(req_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr0 = '0; req_addr1 = '0;
        req_len0 = '0; req_len1 = '0; req_last = 1'b0; strobe_clks = 4'd1;
        hold_busy = 1'b0; cur_tag = 0; busy_clks = 2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(req_ready && nand_we_n && !nand_cle && !nand_ale && !seq_done && !seq_err,
              "R12 reset state", {req_ready, nand_we_n, nand_cle, nand_ale, seq_done, seq_err}, 6'b110000);

        // plain cached pair, then a final pair with a wider strobe
        run_pair(mkaddr(5, 0, 3, 0), mkaddr(5, 1, 3, 0), 4, 3, 1'b0, 1, 1, 6, 0, 1'b1, "");
        run_pair(mkaddr(5, 0, 4, 16), mkaddr(5, 1, 4, 16), 2, 5, 1'b1, 2, 3, 3, 0, 1'b1, "");
        // refusals: R5 plane bits, R6 block mismatch
        run_pair(mkaddr(5, 1, 0, 0), mkaddr(5, 1, 0, 0), 2, 2, 1'b0, 3, 1, 2, 0, 1'b0, "R5 plane-1 first");
        run_pair(mkaddr(5, 0, 0, 0), mkaddr(5, 0, 0, 0), 2, 2, 1'b0, 3, 1, 2, 0, 1'b0, "R5 plane-0 second");
        run_pair(mkaddr(5, 0, 0, 0), mkaddr(7, 1, 0, 0), 2, 2, 1'b0, 3, 1, 2, 0, 1'b0, "R6 block differs");
        // empty and one-byte pages, zero strobe setting, one-clock busy
        run_pair(mkaddr(9, 0, 1, 0), mkaddr(9, 1, 1, 0), 0, 1, 1'b0, 4, 0, 1, 0, 1'b1, "");
        run_pair(mkaddr(9, 0, 2, 0), mkaddr(9, 1, 2, 0), 1, 0, 1'b1, 5, 1, 0, 0, 1'b1, "");
        // request held while ready/busy is low
        run_pair(mkaddr(3, 0, 7, 0), mkaddr(3, 1, 8, 0), 2, 2, 1'b1, 6, 2, 2, 5, 1'b1, "");
        // repeated cached pairs closed by a final one
        for (int i = 0; i < 3; i++)
            run_pair(mkaddr(11, 0, i, 0), mkaddr(11, 1, i, 0), 3, 2, (i == 2), 10 + i, 2, 4, 0, 1'b1, "");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule